// File: doc/BRIEF.md
# UART Interrupt Aggregator with Edge-Latched Sources

This block gathers the interrupt conditions of a UART with 16-entry receive and transmit FIFOs and presents them on a single level-sensitive interrupt line. It does not hold the FIFOs or the serial logic. The current receive and transmit fill levels and a receive-timeout indication come in as inputs. From these the block derives three conditions:

- the receive level has reached its trigger level;
- the transmit level has dropped to its trigger level;
- a receive timeout has occurred.

Each condition is latched into a sticky pending flag only on its rising edge. The line is high while any pending flag has its enable set. A condition that is already true raises nothing new. Software must therefore put bytes into the transmit FIFO first, so that a later drain across the trigger produces the event.

Software reaches two registers through a simple single-cycle bus. The control word holds the three enables and both trigger levels. The status word holds the three pending flags, each cleared by writing 1 to it. Only CPU-driven transfer is assumed, and there is no DMA request path.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset, irq is 0, the control word (address 0) reads 0 and the status word (address 1) reads 0.
- R2: Control word fields:
  - bit 9 enables the receive timeout;
  - bit 12 enables the receive trigger;
  - bit 13 enables the transmit trigger;
  - bits [20:16] hold the receive trigger level;
  - bits [28:24] hold the transmit trigger level.
  
  All other bits read as 0.
- R3: The receive-trigger condition is rx_level >= receive trigger level. It sets status bit 4 only in a cycle where it is true and was false on the previous clock.
- R4: The transmit-trigger condition is tx_level <= transmit trigger level. It sets status bit 5 only on its 0-to-1 transition. Enabling it while it is already true does not assert irq.
- R5: A rise of rx_timeout sets status bit 9. Holding rx_timeout high produces no further event.
- R6: Writing 1 to a status bit clears it. Writing 0 has no effect. Writing 0x3F0 clears all flags. Status bits outside 0x3F0 read 0.
- R7: If a new edge coincides with a write-1-to-clear of the same bit, the bit stays set.
- R8: irq is 1 exactly when some status bit is set and its enable is set. This takes effect on the clock after the flag or enable changes.
- R9: A pending bit stays set while its enable is clear. Setting the enable later asserts irq without a new edge.
- R10: A receive trigger level of 16 (full FIFO) is honoured: the flag sets when rx_level goes from 15 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address: 0 control, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rx_level | input | 5 | Receive FIFO fill level, 0..16 |
| tx_level | input | 5 | Transmit FIFO fill level, 0..16 |
| rx_timeout | input | 1 | Receive timeout indication |
| irq | output | 1 | Level-sensitive combined interrupt |

## Verification
The bench enables the transmit trigger while the FIFO is already drained. A level-sensitive design would assert irq there at once. It then primes the FIFO and drains it again to see the single event arrive.

The bench collides a clear with a fresh timeout edge. A design where the clear wins would lose that interrupt.

It writes zeros and writes to the whole flag mask to confirm that zeros leave flags alone. It disables and re-enables a pending source, to catch a design that drops flags while masked or needs a new edge after unmasking.

It holds conditions high across cycles to catch repeated latching. It also drives the receive level to a full FIFO at trigger level 16, where a narrow compare would miss the crossing.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC      = 3;
  localparam int SRC_RXTRG = 0;
  localparam int SRC_TXTRG = 1;
  localparam int SRC_RXTO  = 2;

  localparam int FIFO_DEPTH = 16;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

  localparam int RXTRIG_LSB = 16;
  localparam int TXTRIG_LSB = 24;
  localparam logic [DATA_W-1:0] STAT_MASK = 32'h0000_03F0;

  // enable bit position of a source in the control word
  function automatic int en_bit(input int src);
    case (src)
      SRC_RXTRG: en_bit = 12;
      SRC_TXTRG: en_bit = 13;
      default:   en_bit = 9;
    endcase
  endfunction

  // pending bit position of a source in the status word
  function automatic int pend_bit(input int src);
    case (src)
      SRC_RXTRG: pend_bit = 4;
      SRC_TXTRG: pend_bit = 5;
      default:   pend_bit = 9;
    endcase
  endfunction

  function automatic logic at_or_above(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] trig);
    at_or_above = (lvl >= trig);
  endfunction

  function automatic logic at_or_below(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] trig);
    at_or_below = (lvl <= trig);
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   en,
  output logic [LVL_W-1:0]  rx_trig,
  output logic [LVL_W-1:0]  tx_trig,
  output logic [DATA_W-1:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      rx_trig <= '0;
      tx_trig <= '0;
    end else if (wr) begin
      for (int s = 0; s < NSRC; s++) en[s] <= wdata[en_bit(s)];
      rx_trig <= wdata[RXTRIG_LSB +: LVL_W];
      tx_trig <= wdata[TXTRIG_LSB +: LVL_W];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < NSRC; s++) rd_val[en_bit(s)] = en[s];
    rd_val[RXTRIG_LSB +: LVL_W] = rx_trig;
    rd_val[TXTRIG_LSB +: LVL_W] = tx_trig;
  end
endmodule

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_src
    // history starts high so a condition already true at reset is no edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b1;
      else        prev[i] <= cond[i];
    end
    assign rise[i] = cond[i] & ~prev[i];
  end
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (set[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              rx_timeout,
  output logic              irq
);
  logic [NSRC-1:0]   en;
  logic [LVL_W-1:0]  rx_trig, tx_trig;
  logic [DATA_W-1:0] ctrl_val, stat_val;
  logic [NSRC-1:0]   cond, rise, clr, pend;
  logic              ctrl_wr, stat_wr;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
  assign stat_wr = bus_we && (bus_addr == ADDR_STAT);

  uart_irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata),
    .en(en), .rx_trig(rx_trig), .tx_trig(tx_trig), .rd_val(ctrl_val)
  );

  always_comb begin
    cond = '0;
    cond[SRC_RXTRG] = at_or_above(rx_level, rx_trig);
    cond[SRC_TXTRG] = at_or_below(tx_level, tx_trig);
    cond[SRC_RXTO]  = rx_timeout;
  end

  uart_irq_edge #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .cond(cond), .rise(rise)
  );

  always_comb begin
    for (int s = 0; s < NSRC; s++) clr[s] = stat_wr & bus_wdata[pend_bit(s)];
  end

  uart_irq_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(rise), .clr(clr), .pend(pend)
  );

  always_comb begin
    stat_val = '0;
    for (int s = 0; s < NSRC; s++) stat_val[pend_bit(s)] = pend[s];
    stat_val = stat_val & STAT_MASK;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_val;
      ADDR_STAT: bus_rdata = stat_val;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = |(pend & en);
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] rise,
  input logic [NSRC-1:0] clr,
  input logic [NSRC-1:0] pend
);
  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(rise)) == '0)); // R3

  AST_EDGE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0)); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & $past(clr) & ~$past(rise)) == '0)); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise) & ~pend) == '0)); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend ^ $past(pend)) & ~$past(clr | rise)) == '0)); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != '0 && pend != '0)); // R8
endmodule

bind uart_irq_agg uart_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .en(en),
  .rise(rise), .clr(clr), .pend(pend)
);

// File: tb/sim_uart_irq_agg.sv
module sim_uart_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  rx_level = '0;
  logic [4:0]  tx_level = '0;
  logic        rx_timeout = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .rx_timeout(rx_timeout), .irq(irq)
  );

  // control word built from the R2 field layout
  function automatic logic [31:0] ctrl_word(input bit e_to, input bit e_rx,
      input bit e_tx, input int rxt, input int txt);
    logic [31:0] w = '0;
    w[9] = e_to; w[12] = e_rx; w[13] = e_tx;
    w[20:16] = rxt[4:0]; w[28:24] = txt[4:0];
    return w;
  endfunction

  localparam logic [31:0] C_ALL  = 32'h0408_3200; // rx trig 8, tx trig 4, all on
  localparam logic [31:0] C_NOTO = 32'h0408_3000;
  localparam logic [31:0] C_TX   = 32'h0400_2000;

  // {rx_level, tx_level, timeout, we, addr, wdata, exp_irq, exp_stat}
  typedef struct packed {
    logic [4:0]  rxl;
    logic [4:0]  txl;
    logic        to;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wd;
    logic        eirq;
    logic [31:0] estat;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  5'd0, 1'b0, 1'b1, 2'd0, C_ALL,        1'b0, 32'h000}, // R2 setup
    '{5'd0,  5'd0, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 32'h000}, // R4 already low
    '{5'd0,  5'd6, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 32'h000}, // R4 prime
    '{5'd0,  5'd4, 1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 32'h020}, // R4 crossing
    '{5'd0,  5'd3, 1'b0, 1'b1, 2'd1, 32'h20,       1'b0, 32'h000}, // R6 clear
    '{5'd7,  5'd3, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 32'h000}, // R3 below
    '{5'd8,  5'd3, 1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 32'h010}, // R3 at trig
    '{5'd12, 5'd3, 1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 32'h010}, // R3 held
    '{5'd12, 5'd3, 1'b0, 1'b1, 2'd1, 32'h0,        1'b1, 32'h010}, // R6 zero write
    '{5'd12, 5'd3, 1'b0, 1'b1, 2'd1, 32'h3F0,      1'b0, 32'h000}, // R6 mask clear
    '{5'd12, 5'd3, 1'b1, 1'b0, 2'd0, 32'h0,        1'b1, 32'h200}, // R5 rise
    '{5'd12, 5'd3, 1'b0, 1'b1, 2'd0, C_NOTO,       1'b0, 32'h200}, // R9 masked
    '{5'd12, 5'd3, 1'b0, 1'b1, 2'd0, C_ALL,        1'b1, 32'h200}, // R9 unmask
    '{5'd12, 5'd3, 1'b1, 1'b1, 2'd1, 32'h200,      1'b1, 32'h200}, // R7 collide
    '{5'd12, 5'd3, 1'b0, 1'b1, 2'd1, 32'h3F0,      1'b0, 32'h000}, // R6 clear all
    '{5'd12, 5'd3, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 32'h000}, // R8 all off
    '{5'd12, 5'd3, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 32'h000}, // R4 tx cond false
    '{5'd12, 5'd0, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 32'h020}, // R9 pend, disabled
    '{5'd12, 5'd0, 1'b0, 1'b1, 2'd0, C_TX,         1'b1, 32'h020}  // R9 enable later
  };

  task automatic check32(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
    bus_we = 1'b0; bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check32("R1 irq", {31'd0, irq}, 32'd0);
    read_reg(2'd0, v); check32("R1 ctrl", v, 32'd0);
    read_reg(2'd1, v); check32("R1 stat", v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rx_level = VEC[i].rxl; tx_level = VEC[i].txl; rx_timeout = VEC[i].to;
      bus_we = VEC[i].we; bus_addr = VEC[i].addr; bus_wdata = VEC[i].wd;
      @(posedge clk); #1;
      bus_we = 1'b0;
      read_reg(2'd1, v);
      check32($sformatf("R8 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i].eirq});
      check32($sformatf("R6 vec%0d stat", i), v, VEC[i].estat);
    end

    // R2 control readback with unused bits dropped
    write_reg(2'd0, 32'hFFFF_FFFF);
    read_reg(2'd0, v);
    check32("R2 ctrl mask", v, ctrl_word(1, 1, 1, 31, 31));
    // R6 status never shows bits outside the flag mask
    write_reg(2'd1, 32'hFFFF_FFFF);
    read_reg(2'd1, v);
    check32("R6 stat outside mask", v & ~32'h3F0, 32'd0);

    // R10 full-FIFO trigger level
    write_reg(2'd1, 32'h3F0);
    rx_level = 5'd15; tx_level = 5'd10; rx_timeout = 1'b0;
    write_reg(2'd0, ctrl_word(0, 1, 0, 16, 0));
    @(negedge clk);
    read_reg(2'd1, v);
    check32("R10 at 15", v, 32'h000);
    rx_level = 5'd16;
    @(negedge clk);
    read_reg(2'd1, v);
    check32("R10 at 16", v, 32'h010);
    check32("R10 irq", {31'd0, irq}, 32'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule